// File: doc/BRIEF.md
# I2C Register-Read Target

This block is a target on a two-wire serial bus. It holds a small bank of byte-wide registers and returns their contents to a bus controller through a combined transfer. The controller first sends a write-direction address phase whose only payload is a register index. It then issues a repeated start and a read-direction address phase. The target answers with bytes taken from that index and the indices that follow, for as long as the controller acknowledges them.

Both bus lines arrive as raw inputs. The target samples them on its own system clock through two-flop synchronizers and finds bus events from the synchronized levels. SDA is driven open-drain through an output-enable. The SCL output-enable exists only for pad compatibility, because the target never stretches the clock. A parallel load port fills the register bank from the chip side.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the target drives neither line: `sdaOe`, `sclOe`, `sdaOut` and `sclOut` are all 0.
- R2: After a start, when the 7 address bits (MSB first) match `DEV_ADDR` and are followed by R/W = 0, the target pulls SDA low for the whole ninth clock.
- R3: When the address does not match, the target leaves SDA released during the ninth clock and during every later clock, up to the next start.
- R4: In a write phase, the target acknowledges the byte after the address. The low `REG_ADDR_W` bits of that byte become the register pointer, and its upper bits are ignored.
- R5: After a repeated start and a matching address with R/W = 1, the target acknowledges and then sends the register at the pointer, MSB first. It changes each bit while SCL is low.
- R6: Once each byte has been sent, the pointer advances by one. When the controller acknowledges, the next register follows. Past the last register the pointer wraps to index 0.
- R7: When the controller does not acknowledge a data byte, the target releases SDA. It drives nothing more until a start, so further clocks read all ones.
- R8: A start or repeated start returns the target to address reception and keeps the pointer. A read-direction phase with no write phase before it returns the register at the current pointer.
- R9: When `loadEn` is high at a clock edge, `loadData` is written into register `loadIdx`, and later reads return the written value.
- R10: In a write phase, bytes after the index byte are not acknowledged. They change neither the registers nor the pointer.
- R11: After a stop, the target stays released until the next start, whatever clocks appear on the bus.
- R12: Apart from releasing SDA on a start or a stop, the target changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock level from the pad |
| sclOut | output | 1 | Bus clock output value, always 0 |
| sclOe | output | 1 | Bus clock output enable, always 0 (no stretching) |
| sdaIn | input | 1 | Bus data level from the pad |
| sdaOut | output | 1 | Bus data output value, always 0 (open-drain) |
| sdaOe | output | 1 | Bus data output enable; 1 pulls SDA low |
| loadEn | input | 1 | Register preload strobe |
| loadIdx | input | REG_ADDR_W | Register index to preload |
| loadData | input | 8 | Byte to preload |

## Verification
The bench builds the target with `REG_ADDR_W` = 3, which gives eight registers. A five-byte read that starts at index 5 therefore crosses the wrap from the top index to index 0. `DEV_ADDR` is 7'h2D, and the mismatch test uses 7'h2C, so the rejected address differs from the real one only in its last bit. Index bytes such as 8'hF3 carry upper bits that the three-bit pointer must discard.

// File: rtl/i2c_reg_target_pkg.sv
package i2c_reg_target_pkg;

  // What the SDA pad enable should do this cycle
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_ACK  = 2'd1,
    DRV_DATA = 2'd2
  } drive_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   cntClr;
    logic   ptrLoad;
    logic   ptrInc;
    logic   txLoad;
    logic   txShift;
    drive_e drive;
  } ctl_strobe_t;

  // Bus events and flags from datapath to control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sdaLvl;
    logic byteDone;
    logic addrMatch;
    logic rwBit;
  } bus_ev_t;

endpackage

// File: rtl/i2c_reg_target_sync.sv
module i2c_reg_target_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ff <= '1;
        else       ff <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ff <= '1;
        else       ff <= {ff[STAGES-2:0], din};
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/i2c_reg_target_dp.sv
module i2c_reg_target_dp
  import i2c_reg_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2D,
  parameter int         REG_ADDR_W = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic                  loadEn,
  input  logic [REG_ADDR_W-1:0] loadIdx,
  input  logic [7:0]            loadData,
  input  ctl_strobe_t           strobe,
  output bus_ev_t               ev,
  output logic                  sdaOe
);
  localparam int REG_DEPTH = 1 << REG_ADDR_W;

  logic sclS, sdaS, sclD, sdaD;
  logic [2:0] bitCnt;
  logic [7:0] rxShift;
  logic [7:0] txByte;
  logic [REG_ADDR_W-1:0] ptr;
  logic [7:0] regBank [REG_DEPTH];

  i2c_reg_target_sync #(.STAGES(SYNC_STAGES)) i_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  i2c_reg_target_sync #(.STAGES(SYNC_STAGES)) i_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  // Bus events from synchronized levels
  assign ev.startEv   = sclS & sclD & sdaD & ~sdaS;
  assign ev.stopEv    = sclS & sclD & ~sdaD & sdaS;
  assign ev.sclRise   = sclS & ~sclD;
  assign ev.sclFall   = ~sclS & sclD;
  assign ev.sdaLvl    = sdaS;
  assign ev.byteDone  = ev.sclRise & (bitCnt == 3'd7);
  assign ev.addrMatch = (rxShift[7:1] == DEV_ADDR);
  assign ev.rwBit     = rxShift[0];

  // Bit counter and receive shifter
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.cntClr)    bitCnt <= '0;
      else if (ev.sclRise)  bitCnt <= bitCnt + 3'd1;
      if (ev.sclRise)       rxShift <= {rxShift[6:0], sdaS};
    end

  // Register pointer
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              ptr <= '0;
    else if (strobe.ptrLoad) ptr <= rxShift[REG_ADDR_W-1:0];
    else if (strobe.ptrInc)  ptr <= ptr + 1'b1;

  // Register bank with parallel preload
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regBank[i] <= '0;
    end else if (loadEn) begin
      regBank[loadIdx] <= loadData;
    end

  // Transmit shifter
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               txByte <= '0;
    else if (strobe.txLoad)  txByte <= regBank[ptr];
    else if (strobe.txShift) txByte <= {txByte[6:0], 1'b0};

  assign sdaOe = (strobe.drive == DRV_ACK) |
                 ((strobe.drive == DRV_DATA) & ~txByte[7]);

  // R12: SDA enable moves only with SCL low, except release on start/stop
  a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!sclS || $past(ev.startEv || ev.stopEv)));

  // R8: a start leaves the pointer where it was
  a_r8_ptr_kept_on_start: assert property (@(posedge clk) disable iff (!rstN)
    ev.startEv |=> (ptr == $past(ptr)));

  // R6: a pointer step is exactly one, wrapping modulo the bank size
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ptrInc && !strobe.ptrLoad) |=>
      (ptr == REG_ADDR_W'($past(ptr) + 1)));
endmodule

// File: rtl/i2c_reg_target_ctl.sv
module i2c_reg_target_ctl
  import i2c_reg_target_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  bus_ev_t     ev,
  output ctl_strobe_t strobe
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_CHK, ST_ACK_A, ST_SUB, ST_SUB_CHK,
    ST_ACK_S, ST_TX, ST_TX_END, ST_MACK, ST_MACK_OK, ST_IGNORE
  } state_e;

  state_e state, stateN;
  drive_e driveQ, driveN;
  logic   rwQ, rwN;
  logic   cntClr, ptrLoad, ptrInc, txLoad, txShift;

  always_comb begin
    stateN  = state;
    driveN  = driveQ;
    rwN     = rwQ;
    cntClr  = 1'b0;
    ptrLoad = 1'b0;
    ptrInc  = 1'b0;
    txLoad  = 1'b0;
    txShift = 1'b0;
    if (ev.stopEv) begin
      stateN = ST_IDLE;
      driveN = DRV_NONE;
    end else if (ev.startEv) begin
      stateN = ST_ADDR;
      driveN = DRV_NONE;
      cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR:     if (ev.byteDone) stateN = ST_ADDR_CHK;
        ST_ADDR_CHK: if (ev.sclFall) begin
                       if (ev.addrMatch) begin
                         stateN = ST_ACK_A;
                         driveN = DRV_ACK;
                         rwN    = ev.rwBit;
                       end else begin
                         stateN = ST_IGNORE;
                       end
                     end
        ST_ACK_A:    if (ev.sclFall) begin
                       cntClr = 1'b1;
                       if (rwQ) begin
                         stateN = ST_TX;
                         txLoad = 1'b1;
                         driveN = DRV_DATA;
                       end else begin
                         stateN = ST_SUB;
                         driveN = DRV_NONE;
                       end
                     end
        ST_SUB:      if (ev.byteDone) stateN = ST_SUB_CHK;
        ST_SUB_CHK:  if (ev.sclFall) begin
                       ptrLoad = 1'b1;
                       driveN  = DRV_ACK;
                       stateN  = ST_ACK_S;
                     end
        ST_ACK_S:    if (ev.sclFall) begin
                       driveN = DRV_NONE;
                       stateN = ST_IGNORE;
                     end
        ST_TX:       if (ev.byteDone) stateN = ST_TX_END;
                     else if (ev.sclFall) txShift = 1'b1;
        ST_TX_END:   if (ev.sclFall) begin
                       driveN = DRV_NONE;
                       ptrInc = 1'b1;
                       stateN = ST_MACK;
                     end
        ST_MACK:     if (ev.sclRise) stateN = ev.sdaLvl ? ST_IGNORE : ST_MACK_OK;
        ST_MACK_OK:  if (ev.sclFall) begin
                       cntClr = 1'b1;
                       txLoad = 1'b1;
                       driveN = DRV_DATA;
                       stateN = ST_TX;
                     end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state  <= ST_IDLE;
      driveQ <= DRV_NONE;
      rwQ    <= 1'b0;
    end else begin
      state  <= stateN;
      driveQ <= driveN;
      rwQ    <= rwN;
    end

  assign strobe.cntClr  = cntClr;
  assign strobe.ptrLoad = ptrLoad;
  assign strobe.ptrInc  = ptrInc;
  assign strobe.txLoad  = txLoad;
  assign strobe.txShift = txShift;
  assign strobe.drive   = driveQ;

  // R11: a stop always leaves the target idle and released
  a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopEv |=> (driveQ == DRV_NONE && state == ST_IDLE));

  // R7: a controller NACK ends driving
  a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MACK && ev.sclRise && ev.sdaLvl && !ev.stopEv && !ev.startEv)
      |=> (driveQ == DRV_NONE));

  // R2: an acknowledge only begins after an SCL fall
  a_r2_ack_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveQ == DRV_ACK) |-> $past(ev.sclFall));

  // R3: a mismatched address is never acknowledged
  a_r3_unmatched_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_CHK && ev.sclFall && !ev.addrMatch && !ev.startEv && !ev.stopEv)
      |=> (driveQ == DRV_NONE));

  // R4: loading the pointer goes with acknowledging the index byte
  a_r4_index_acked: assert property (@(posedge clk) disable iff (!rstN)
    ptrLoad |=> (driveQ == DRV_ACK));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2D,
  parameter int         REG_ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  output logic                  sclOut,
  output logic                  sclOe,
  input  logic                  sdaIn,
  output logic                  sdaOut,
  output logic                  sdaOe,
  input  logic                  loadEn,
  input  logic [REG_ADDR_W-1:0] loadIdx,
  input  logic [7:0]            loadData
);
  ctl_strobe_t strobe;
  bus_ev_t     ev;

  i2c_reg_target_dp #(
    .DEV_ADDR(DEV_ADDR), .REG_ADDR_W(REG_ADDR_W), .SYNC_STAGES(2)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .strobe(strobe), .ev(ev), .sdaOe(sdaOe)
  );

  i2c_reg_target_ctl i_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .strobe(strobe)
  );

  assign sclOut = 1'b0;
  assign sclOe  = 1'b0;
  assign sdaOut = 1'b0;

  // R1: pads quiet while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!sdaOe && !sclOe));
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h2D;
  localparam int AW = 3;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrvLow = 1'b0;
  logic sclOut, sclOe, sdaOut, sdaOe;
  logic loadEn = 1'b0;
  logic [AW-1:0] loadIdx = '0;
  logic [7:0] loadData = '0;
  logic sdaBus;
  logic monOn = 1'b0;
  int checks = 0;
  int errors = 0;
  logic [7:0] expReg [NREG];

  always #2 clk = ~clk;

  assign sdaBus = !(sdaDrvLow || sdaOe);

  i2c_reg_target #(.DEV_ADDR(DEV), .REG_ADDR_W(AW)) i_i2c_reg_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sclOut(sclOut), .sclOe(sclOe),
    .sdaIn(sdaBus), .sdaOut(sdaOut), .sdaOe(sdaOe),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R12 monitor: each SDA enable change must happen with SCL low
  always @(sdaOe) if (monOn) check(sclDrv == 1'b0, "R12", int'(sclDrv), 0);

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrvLow = 1'b0; sclDrv = 1'b1; q();
    sdaDrvLow = 1'b1; q();
    sclDrv = 1'b0; q();
  endtask

  task automatic busRestart();
    sdaDrvLow = 1'b0; q();
    sclDrv = 1'b1; q();
    sdaDrvLow = 1'b1; q();
    sclDrv = 1'b0; q();
  endtask

  task automatic busStop();
    sdaDrvLow = 1'b1; q();
    sclDrv = 1'b1; q();
    sdaDrvLow = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackLow);
    for (int i = 7; i >= 0; i--) begin
      sdaDrvLow = ~b[i]; q();
      sclDrv = 1'b1; q(); q();
      sclDrv = 1'b0; q();
    end
    sdaDrvLow = 1'b0; q();
    sclDrv = 1'b1; q();
    ackLow = ~sdaBus; q();
    sclDrv = 1'b0; q();
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] d);
    sdaDrvLow = 1'b0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      q();
      sclDrv = 1'b1; q();
      d = {d[6:0], sdaBus}; q();
      sclDrv = 1'b0;
    end
    q();
    sdaDrvLow = ackIt; q();
    sclDrv = 1'b1; q(); q();
    sclDrv = 1'b0; q();
    sdaDrvLow = 1'b0;
  endtask

  task automatic preload(input int idx, input logic [7:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = AW'(idx); loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
    expReg[idx] = val;
  endtask

  // Combined read: index write, repeated start, n bytes, stop
  task automatic combinedRead(input logic [7:0] idxByte, input int n, input bit doStop);
    logic ack;
    logic [7:0] d;
    int base;
    base = int'(idxByte) % NREG;
    busStart();
    sendByte({DEV, 1'b0}, ack);
    check(ack == 1'b1, "R2 write address ack", int'(ack), 1);
    sendByte(idxByte, ack);
    check(ack == 1'b1, "R4 index ack", int'(ack), 1);
    busRestart();
    sendByte({DEV, 1'b1}, ack);
    check(ack == 1'b1, "R5 read address ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      readByte(k != n - 1, d);
      check(d == expReg[(base + k) % NREG], (n > 1) ? "R6 sequential data" : "R5 data",
            int'(d), int'(expReg[(base + k) % NREG]));
    end
    if (doStop) busStop();
  endtask

  task automatic tReset();
    check(sdaOe == 1'b0 && sclOe == 1'b0 && sdaOut == 1'b0 && sclOut == 1'b0, "R1",
          int'({sdaOe, sclOe, sdaOut, sclOut}), 0);
  endtask

  task automatic tWrongAddr();
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte({7'h2C, 1'b0}, ack);
    check(ack == 1'b0, "R3 mismatch no ack", int'(ack), 0);
    sendByte(8'h00, ack);
    check(ack == 1'b0, "R3 later byte no ack", int'(ack), 0);
    readByte(1'b0, d);
    check(d == 8'hFF, "R3 bus left released", int'(d), 8'hFF);
    busStop();
  endtask

  task automatic tNackRelease();
    logic [7:0] d;
    combinedRead(8'h01, 1, 1'b0);
    readByte(1'b0, d);
    check(d == 8'hFF, "R7 released after NACK", int'(d), 8'hFF);
    busStop();
  endtask

  task automatic tRestartKeepsPtr();
    logic ack;
    logic [7:0] d;
    combinedRead(8'h06, 1, 1'b0);
    busRestart();
    sendByte({DEV, 1'b1}, ack);
    check(ack == 1'b1, "R8 read address ack", int'(ack), 1);
    readByte(1'b0, d);
    check(d == expReg[7], "R8 pointer kept", int'(d), int'(expReg[7]));
    busStop();
  endtask

  task automatic tExtraWrite();
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'h04, ack);
    check(ack == 1'b1, "R4 index ack", int'(ack), 1);
    sendByte(8'h99, ack);
    check(ack == 1'b0, "R10 extra byte not acked", int'(ack), 0);
    busStop();
    busStart();
    sendByte({DEV, 1'b1}, ack);
    readByte(1'b0, d);
    check(d == expReg[4], "R10 pointer and data unchanged", int'(d), int'(expReg[4]));
    busStop();
  endtask

  task automatic tAfterStop();
    logic [7:0] d;
    readByte(1'b0, d);
    check(d == 8'hFF, "R11 idle after stop", int'(d), 8'hFF);
    sclDrv = 1'b1; sdaDrvLow = 1'b0; q();
  endtask

  task automatic tPreloadLive();
    preload(0, 8'hC3);
    combinedRead(8'h00, 1, 1'b1);
    check(expReg[0] == 8'hC3, "R9 preload model", int'(expReg[0]), 8'hC3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    monOn = 1'b1;
    for (int i = 0; i < NREG; i++) preload(i, 8'((i * 91 + 23) ^ 8'h40));  // R9
    combinedRead(8'h02, 1, 1'b1);   // R2 R4 R5
    combinedRead(8'h05, 5, 1'b1);   // R6 wrap 5,6,7,0,1
    combinedRead(8'hF3, 2, 1'b1);   // R4 upper bits ignored
    tWrongAddr();
    tNackRelease();
    tRestartKeepsPtr();
    tExtraWrite();
    tAfterStop();
    tPreloadLive();
    tReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule